// File: doc/BRIEF.md
# Overlay Upload Controller

This block sits beside the sequencer of a small 8-bit core and takes over when the core executes an overlay request. An overlay request is a call instruction whose target byte equals the current program counter, so it acts as a jump to itself. It is also raised by an all-ones instruction word, which the core otherwise treats as invalid. With the second form, fetching erased program memory stops the core, and the core waits for a replacement word to be supplied.

On a request the block loads the program counter with the target address and raises a halt that freezes fetch and register writes. It then accepts two words from a host over a valid/ready stream. The first is an instruction word and the second is a CRC-16 of that word. The host may leave `up_valid` low for any number of cycles. `up_ready` is high only while a word is awaited, and a word transfers only in a cycle where both signals are high. When the CRC matches, the word is written into instruction SRAM at the target address and the core resumes fetching from there. When the CRC does not match, the word is discarded. A strap input then chooses between two outcomes: the block stays halted until reset, or it pulses a hard reset for the core.

Top module: `ovl_upload_ctrl`

## Requirements
- R1: After reset, `core_halt`, `up_ready`, `pc_load`, `sram_we`, `crc_ok`, `crc_err` and `core_reset` are all 0.
- R2: A decoded word is an overlay request if its upper byte equals the call opcode (default 8'h5C) and its lower byte equals `cur_pc`. One cycle after such a word is presented with `dec_valid` high while idle, `pc_load` pulses with `pc_target` equal to the lower byte, and `core_halt` rises.
- R3: A call word (upper byte 8'h5C) whose lower byte differs from `cur_pc` is not an overlay request. `core_halt` and `pc_load` stay 0.
- R4: The word 16'hFFFF is an overlay request for any `cur_pc`. One cycle later, `pc_load` pulses with `pc_target` = 8'hFF and `core_halt` rises.
- R5: `up_ready` is high only while halted and awaiting a word. Outside upload, asserting `up_valid` has no effect: `up_ready`, `core_halt` and `sram_we` stay 0.
- R6: An upload consists of exactly two accepted transfers: first the instruction word, then the CRC word. Cycles in which `up_valid` is low leave the wait in place.
- R7: The CRC is CRC-16 with polynomial 0x1021 and initial value 16'hFFFF. It is computed MSB first over the 16-bit word, with no reflection and no final XOR. If the CRC word matches, then one cycle after it is accepted `sram_we` is high for exactly one cycle, with `sram_addr` set to the target and `sram_wdata` set to the word. One cycle after that, `pc_load` pulses with the target, `crc_ok` pulses, and `core_halt` falls.
- R8: With `bad_crc_reboot` = 0, a CRC mismatch leaves `core_halt` and `crc_err` high, with `up_ready` 0 and `sram_we` 0, until reset.
- R9: With `bad_crc_reboot` = 1, `core_reset` and `crc_err` pulse for one cycle, starting one cycle after a mismatching CRC is accepted. Neither `sram_we` nor `pc_load` is raised. The next cycle, `core_halt` is 0.
- R10: While an upload is in progress, `dec_valid` has no effect: no `pc_load`, and the committed address stays the original target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bad_crc_reboot | input | 1 | 1: mismatch pulses `core_reset`; 0: mismatch halts until reset |
| dec_valid | input | 1 | A decoded instruction word is present |
| dec_word | input | 16 | Decoded instruction word |
| cur_pc | input | 8 | Program counter of the decoded word |
| pc_load | output | 1 | One-cycle request to load the PC |
| pc_target | output | 8 | PC value to load |
| core_halt | output | 1 | Freezes fetch and register writes |
| up_valid | input | 1 | Host word valid |
| up_data | input | 16 | Host word (instruction, then CRC) |
| up_ready | output | 1 | Block accepts a host word |
| sram_we | output | 1 | Instruction SRAM write strobe |
| sram_addr | output | 8 | Instruction SRAM write address |
| sram_wdata | output | 16 | Instruction SRAM write data |
| crc_ok | output | 1 | Pulse on a successful commit |
| crc_err | output | 1 | CRC mismatch (level when stuck, pulse on reboot) |
| core_reset | output | 1 | One-cycle hard reset request for the core |

## Verification
The hardest situation to reach is an overlay request that arrives while an upload is already waiting. A commit must still land at the first target, so the stimulus presents a second, differently targeted overlay word between the two host transfers. It also leaves the host idle for several cycles, so that the stall and the ignored decode overlap. Both outcomes of a mismatched CRC are reached by flipping one bit of the correct CRC under each setting of the strap, and the stuck case is then left only through reset.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WORD   = 3'd1,
    ST_CRC    = 3'd2,
    ST_COMMIT = 3'd3,
    ST_REBOOT = 3'd4,
    ST_STUCK  = 3'd5
  } ovl_state_e;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;
endpackage

// File: rtl/ovl_decode.sv
module ovl_decode #(
  parameter int IW = 16,
  parameter int AW = 8,
  parameter logic [IW-AW-1:0] CALL_OPC = 8'h5C
) (
  input  logic          dec_valid,
  input  logic [IW-1:0] dec_word,
  input  logic [AW-1:0] cur_pc,
  output logic          hit,
  output logic [AW-1:0] hit_target
);
  logic self_call;
  logic all_ones;

  always_comb begin
    self_call  = (dec_word[IW-1:AW] == CALL_OPC) && (dec_word[AW-1:0] == cur_pc);
    all_ones   = &dec_word;
    hit        = dec_valid && (self_call || all_ones);
    hit_target = all_ones ? {AW{1'b1}} : dec_word[AW-1:0];
  end
endmodule

// File: rtl/ovl_crc16.sv
module ovl_crc16 #(
  parameter int W = 16,
  parameter logic [15:0] POLY = ovl_pkg::CRC_POLY,
  parameter logic [15:0] INIT = ovl_pkg::CRC_INIT
) (
  input  logic [W-1:0] data,
  output logic [15:0]  crc
);
  logic [15:0] stage [0:W];

  assign stage[0] = INIT;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic fb;
    assign fb = stage[i][15] ^ data[W-1-i];
    assign stage[i+1] = {stage[i][14:0], 1'b0} ^ (fb ? POLY : 16'h0000);
  end

  assign crc = stage[W];
endmodule

// File: rtl/ovl_datapath.sv
module ovl_datapath #(
  parameter int IW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_target,
  input  logic [AW-1:0] target_in,
  input  logic          cap_word,
  input  logic [IW-1:0] up_data,
  output logic [AW-1:0] target_q,
  output logic [IW-1:0] word_q,
  output logic          crc_match
);
  logic [15:0] crc_now;
  logic [15:0] crc_q;

  ovl_crc16 #(.W(IW)) u_crc (
    .data (up_data),
    .crc  (crc_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target_q <= '0;
      word_q   <= '0;
      crc_q    <= '0;
    end else begin
      if (cap_target) target_q <= target_in;
      if (cap_word) begin
        word_q <= up_data;
        crc_q  <= crc_now;
      end
    end
  end

  assign crc_match = (up_data[15:0] == crc_q);

  assert_target_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_target |=> $stable(target_q));
endmodule

// File: rtl/ovl_fsm.sv
module ovl_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic bad_crc_reboot,
  input  logic hit,
  input  logic up_valid,
  input  logic crc_match,
  output logic cap_target,
  output logic cap_word,
  output logic up_ready,
  output logic halt,
  output logic pc_load,
  output logic sram_we,
  output logic crc_ok,
  output logic crc_err,
  output logic core_reset
);
  import ovl_pkg::*;

  ovl_state_e state, state_nx;
  logic acc;

  always_comb begin
    up_ready   = (state == ST_WORD) || (state == ST_CRC);
    acc        = up_ready && up_valid;
    cap_target = (state == ST_IDLE) && hit;
    cap_word   = (state == ST_WORD) && acc;
    state_nx   = state;
    unique case (state)
      ST_IDLE:   if (hit) state_nx = ST_WORD;
      ST_WORD:   if (acc) state_nx = ST_CRC;
      ST_CRC:    if (acc) state_nx = crc_match ? ST_COMMIT :
                                     (bad_crc_reboot ? ST_REBOOT : ST_STUCK);
      ST_COMMIT: state_nx = ST_IDLE;
      ST_REBOOT: state_nx = ST_IDLE;
      ST_STUCK:  state_nx = ST_STUCK;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      pc_load    <= 1'b0;
      sram_we    <= 1'b0;
      crc_ok     <= 1'b0;
      core_reset <= 1'b0;
    end else begin
      state      <= state_nx;
      pc_load    <= cap_target || (state == ST_COMMIT);
      crc_ok     <= (state == ST_COMMIT);
      sram_we    <= (state == ST_CRC) && acc && crc_match;
      core_reset <= (state == ST_CRC) && acc && !crc_match && bad_crc_reboot;
    end
  end

  assign halt    = (state != ST_IDLE);
  assign crc_err = (state == ST_STUCK) || core_reset;

  assert_hit_halts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && hit) |=> (pc_load && halt));
  assert_we_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |=> (!sram_we && pc_load && !halt && crc_ok));
  assert_stuck_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STUCK) |=> (halt && crc_err && !up_ready && !sram_we));
  assert_reboot_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset |=> (!core_reset && !halt && !pc_load));
  assert_busy_no_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && state != ST_COMMIT) |=> !pc_load);
endmodule

// File: rtl/ovl_upload_ctrl.sv
module ovl_upload_ctrl #(
  parameter int IW = 16,
  parameter int AW = 8,
  parameter logic [IW-AW-1:0] CALL_OPC = 8'h5C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bad_crc_reboot,
  input  logic          dec_valid,
  input  logic [IW-1:0] dec_word,
  input  logic [AW-1:0] cur_pc,
  output logic          pc_load,
  output logic [AW-1:0] pc_target,
  output logic          core_halt,
  input  logic          up_valid,
  input  logic [IW-1:0] up_data,
  output logic          up_ready,
  output logic          sram_we,
  output logic [AW-1:0] sram_addr,
  output logic [IW-1:0] sram_wdata,
  output logic          crc_ok,
  output logic          crc_err,
  output logic          core_reset
);
  logic          hit;
  logic [AW-1:0] hit_target;
  logic          cap_target;
  logic          cap_word;
  logic          crc_match;
  logic [AW-1:0] target_q;
  logic [IW-1:0] word_q;

  ovl_decode #(.IW(IW), .AW(AW), .CALL_OPC(CALL_OPC)) u_dec (
    .dec_valid  (dec_valid),
    .dec_word   (dec_word),
    .cur_pc     (cur_pc),
    .hit        (hit),
    .hit_target (hit_target)
  );

  ovl_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .bad_crc_reboot (bad_crc_reboot),
    .hit            (hit),
    .up_valid       (up_valid),
    .crc_match      (crc_match),
    .cap_target     (cap_target),
    .cap_word       (cap_word),
    .up_ready       (up_ready),
    .halt           (core_halt),
    .pc_load        (pc_load),
    .sram_we        (sram_we),
    .crc_ok         (crc_ok),
    .crc_err        (crc_err),
    .core_reset     (core_reset)
  );

  ovl_datapath #(.IW(IW), .AW(AW)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_target (cap_target),
    .target_in  (hit_target),
    .cap_word   (cap_word),
    .up_data    (up_data),
    .target_q   (target_q),
    .word_q     (word_q),
    .crc_match  (crc_match)
  );

  assign pc_target  = target_q;
  assign sram_addr  = target_q;
  assign sram_wdata = word_q;

  assert_ready_only_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    up_ready |-> core_halt);
  assert_we_while_halted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |-> (core_halt && !up_ready));
endmodule

// File: tb/tb_ovl_upload_ctrl.sv
module tb_ovl_upload_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bad_crc_reboot = 1'b0;
  logic        dec_valid = 1'b0;
  logic [15:0] dec_word = '0;
  logic [7:0]  cur_pc = '0;
  logic        pc_load;
  logic [7:0]  pc_target;
  logic        core_halt;
  logic        up_valid = 1'b0;
  logic [15:0] up_data = '0;
  logic        up_ready;
  logic        sram_we;
  logic [7:0]  sram_addr;
  logic [15:0] sram_wdata;
  logic        crc_ok;
  logic        crc_err;
  logic        core_reset;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ovl_upload_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bad_crc_reboot(bad_crc_reboot),
    .dec_valid(dec_valid), .dec_word(dec_word), .cur_pc(cur_pc),
    .pc_load(pc_load), .pc_target(pc_target), .core_halt(core_halt),
    .up_valid(up_valid), .up_data(up_data), .up_ready(up_ready),
    .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
    .crc_ok(crc_ok), .crc_err(crc_err), .core_reset(core_reset)
  );

  function automatic logic [15:0] ref_crc(input logic [15:0] w);
    logic [15:0] r = 16'hFFFF;
    for (int i = 15; i >= 0; i--) begin
      if (r[15] ^ w[i]) r = (r << 1) ^ 16'h1021;
      else              r = r << 1;
    end
    return r;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; dec_valid = 0; up_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Presents word at a negedge; returns at the next negedge (after the capture edge).
  task automatic decode(input logic [15:0] w, input logic [7:0] pc);
    dec_valid = 1; dec_word = w; cur_pc = pc;
    @(negedge clk);
    dec_valid = 0;
  endtask

  task automatic push(input logic [15:0] d);
    up_valid = 1; up_data = d;
    @(negedge clk);
    up_valid = 0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1", "halt", core_halt, 0);
    chk("R1", "ready", up_ready, 0);
    chk("R1", "pc_load", pc_load, 0);
    chk("R1", "we", sram_we, 0);
    chk("R1", "crc_ok/err/rst", {crc_ok, crc_err, core_reset}, 0);
  endtask

  task automatic t_not_overlay();
    decode(16'h5C33, 8'h34);
    chk("R3", "pc_load", pc_load, 0);
    chk("R3", "halt", core_halt, 0);
    decode(16'h5D20, 8'h20);
    chk("R3", "other opcode halt", core_halt, 0);
    // R5: host writes outside upload are ignored
    up_valid = 1; up_data = 16'hBEEF;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R5", "ready idle", up_ready, 0);
      chk("R5", "halt idle", core_halt, 0);
      chk("R5", "we idle", sram_we, 0);
    end
    up_valid = 0;
  endtask

  task automatic t_good_upload(input logic [15:0] op, input logic [7:0] pc,
                               input logic [7:0] tgt, input logic [15:0] w, input string req);
    decode(op, pc);
    chk(req, "pc_load", pc_load, 1);
    chk(req, "pc_target", pc_target, tgt);
    chk(req, "halt", core_halt, 1);
    chk("R5", "ready in upload", up_ready, 1);
    // R6: host idle cycles, and R10: overlay decode during wait
    dec_valid = 1; dec_word = 16'h5C11; cur_pc = 8'h11;
    @(negedge clk);
    dec_valid = 0;
    chk("R10", "no pc_load in upload", pc_load, 0);
    @(negedge clk);
    chk("R6", "still waiting", up_ready, 1);
    push(w);
    chk("R6", "wait crc", up_ready, 1);
    chk("R6", "no write yet", sram_we, 0);
    @(negedge clk);
    dec_valid = 1; dec_word = 16'hFFFF;
    @(negedge clk);
    dec_valid = 0;
    chk("R10", "no pc_load in crc wait", pc_load, 0);
    push(ref_crc(w));
    chk("R7", "we", sram_we, 1);
    chk("R7", "addr", sram_addr, tgt);
    chk("R10", "addr kept", sram_addr, tgt);
    chk("R7", "wdata", sram_wdata, w);
    chk("R7", "halt at commit", core_halt, 1);
    @(negedge clk);
    chk("R7", "we one cycle", sram_we, 0);
    chk("R7", "resume pc_load", pc_load, 1);
    chk("R7", "resume target", pc_target, tgt);
    chk("R7", "crc_ok", crc_ok, 1);
    chk("R7", "halt released", core_halt, 0);
    @(negedge clk);
    chk("R7", "pc_load pulse", pc_load, 0);
  endtask

  task automatic t_bad_reboot();
    bad_crc_reboot = 1;
    decode(16'hFFFF, 8'h07);
    chk("R4", "target FF", pc_target, 8'hFF);
    push(16'h00A5);
    push(ref_crc(16'h00A5) ^ 16'h0001);
    chk("R9", "core_reset", core_reset, 1);
    chk("R9", "crc_err", crc_err, 1);
    chk("R9", "no we", sram_we, 0);
    chk("R9", "no pc_load", pc_load, 0);
    @(negedge clk);
    chk("R9", "reset pulse ends", core_reset, 0);
    chk("R9", "halt low", core_halt, 0);
    chk("R9", "no we after", sram_we, 0);
    chk("R9", "no pc_load after", pc_load, 0);
  endtask

  task automatic t_bad_stuck();
    bad_crc_reboot = 0;
    decode(16'h5C80, 8'h80);
    push(16'h7E01);
    push(ref_crc(16'h7E01) ^ 16'h8000);
    for (int i = 0; i < 4; i++) begin
      chk("R8", "halt stuck", core_halt, 1);
      chk("R8", "crc_err", crc_err, 1);
      chk("R8", "ready low", up_ready, 0);
      chk("R8", "no we", sram_we, 0);
      chk("R8", "no reset", core_reset, 0);
      up_valid = 1; up_data = ref_crc(16'h7E01);
      dec_valid = 1; dec_word = 16'hFFFF;
      @(negedge clk);
    end
    up_valid = 0; dec_valid = 0;
    chk("R8", "no pc_load while stuck", pc_load, 0);
    do_reset();
    chk("R1", "halt after reset", core_halt, 0);
    chk("R1", "crc_err after reset", crc_err, 0);
  endtask

  initial begin
    t_reset_state();
    t_not_overlay();
    t_good_upload(16'h5C42, 8'h42, 8'h42, 16'h1234, "R2");
    t_good_upload(16'hFFFF, 8'h10, 8'hFF, 16'h9A0C, "R4");
    t_bad_reboot();
    t_bad_stuck();
    repeat (2) @(negedge clk);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule